// File: doc/BRIEF.md
# Host Bus Address Window Mapper

This block takes the starting address of a host bus transaction and decides where it goes: to the memory bus or the register bus, to which device, and at which internal address. Only the upper sixteen address bits are decoded. Several windows overlap, and a set of configuration switches turns each one on or off. These switches are the boot switch, the shadow and extended enables, the save kind, the disk mode, register access and ROM write enable. The windows are checked in a fixed priority, and some of them are read-only.

The result is decided once per transaction. A one-cycle `strobe` marks the starting address. The decoded result is registered at the next clock edge and stays unchanged until the next strobe or reset. Later addresses in the same burst, including those past a 64 KiB boundary, therefore keep the original target.

Control is a two-state machine. `S_EMPTY` is the state after reset and holds no valid translation. `S_HOLD` holds the translation latched by the last strobe. The transition *load* is taken on a strobe in either state and goes to `S_HOLD`, capturing a fresh decode. The transition *clear* is reset, which returns to `S_EMPTY` with all outputs zero.

Top module: `host_window_map`

## Requirements
- R1: After reset, and in any cycle before the first strobe, `hit`, `wr_ok`, `bus_reg`, `dev_sel` and `int_addr` are all zero.
- R2: The translation of the inputs present in a cycle with `strobe`=1 appears on the outputs after the next rising clock edge. Without a strobe, the outputs hold their values whatever `start_addr`, `is_write` or the switches do.
- R3: Only `start_addr[31:16]` selects the window. Lower bits pass into the internal address as an offset, so all addresses in one 64 KiB unit reach the same bus and device.
- R4: With `boot_sel`=1, host units 0x1000..0x101D map to flash (`dev_sel`=2) at 0x04E0_0000 plus offset, read-only. Unit 0x101E and above in that range match nothing.
- R5: With `boot_sel`=0, host 0x1000_0000..0x13FF_FFFF maps to SDRAM (`dev_sel`=1) at address minus 0x1000_0000. `wr_ok` is 1 only for a write with `rom_wr_on`=1.
- R6: With `shadow_on`=1, host 0x13FE_0000..0x13FF_FFFF maps read-only to flash at 0x04FE_0000 plus offset, overriding R5.
- R7: With `ext_on`=1, host 0x1400_0000..0x14DF_FFFF maps read-only to flash at 0x0400_0000 plus offset.
- R8: The save window at host unit 0x0800 depends on `save_kind` (0 none, 1 static RAM 128 KiB, 2 banked, 3 flash save). Kinds 1 and 3 span units 0x0800..0x0801 and map to SDRAM at 0x03FE_0000 plus offset, writable. Kind 2 accepts units 0x0800, 0x0804 and 0x0808 (bank 0, 1, 2) and maps to SDRAM at 0x03FE_0000 + bank×0x8000 + `start_addr[14:0]`. Other units match nothing.
- R9: With `save_kind`=3, writes and reads with `flash_rd_reg`=1 go to the register bus (`bus_reg`=1, `dev_sel`=6) with internal address `start_addr[16:0]`. Reads with `flash_rd_reg`=0 take the memory path of R8.
- R10: `disk_kind` bit 0 enables unit 0x0500 on the register bus (`dev_sel`=5, address `start_addr[15:0]`, writable). Bit 1 enables host 0x0600_0000..0x063F_FFFF read-only to SDRAM at 0x03BC_0000 plus offset.
- R11: With `regs_on`=1, unit 0x1FFF goes to the register bus (`dev_sel`=4, address `start_addr[15:0]`, writable). Unit 0x1FFE goes to block RAM (`dev_sel`=3) at 0x0500_0000 plus offset, writable. Units 0x1FFC..0x1FFD go read-only to flash at 0x04FE_0000 plus offset, regardless of `shadow_on`. With `regs_on`=0, all three match nothing.
- R12: An address matching no enabled window gives `hit`=0, `wr_ok`=0, `bus_reg`=0, `dev_sel`=0 and `int_addr`=0. `wr_ok` is always 0 for reads and for read-only windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Marks the starting address of a transaction |
| start_addr | input | 32 | Host bus starting address |
| is_write | input | 1 | 1 for a write transaction |
| boot_sel | input | 1 | Boot switch: ROM window shows boot flash |
| shadow_on | input | 1 | Enables the shadow redirect at the top of ROM |
| ext_on | input | 1 | Enables the extended flash window |
| save_kind | input | 2 | Save kind: 0 none, 1 static RAM, 2 banked, 3 flash save |
| disk_kind | input | 2 | Disk mode: bit 0 registers, bit 1 loader image |
| regs_on | input | 1 | Register access enable |
| rom_wr_on | input | 1 | Permits writes to the ROM window |
| flash_rd_reg | input | 1 | Flash-save reads use the register bus |
| bus_reg | output | 1 | 0 memory bus, 1 register bus |
| dev_sel | output | 3 | 0 none, 1 SDRAM, 2 flash, 3 block RAM, 4 control regs, 5 disk regs, 6 flash-save controller |
| int_addr | output | 32 | Translated internal address |
| hit | output | 1 | A window matched |
| wr_ok | output | 1 | Write transaction accepted by the window |

## Verification
The hardest situation to reach from the ports is a transfer that crosses a 64 KiB boundary into a window with a different target. The outputs must keep the first target even though the new address would decode elsewhere. The stimulus latches a block RAM address, then drives the register unit just above it, along with changed switches, without a strobe. It checks that nothing moves. The overlaps are reached from the vector table: shadow over writable ROM, the register-access flash window with shadow off, and bank units next to the holes between them.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
    localparam int ADDR_W = 32;
    localparam int UNIT_W = 16;
    localparam int HI_W   = ADDR_W - UNIT_W;

    typedef enum logic [2:0] {
        DEV_NONE   = 3'd0,
        DEV_SDRAM  = 3'd1,
        DEV_FLASH  = 3'd2,
        DEV_BRAM   = 3'd3,
        DEV_CTRL   = 3'd4,
        DEV_DISK   = 3'd5,
        DEV_FSAVE  = 3'd6
    } dev_e;

    typedef enum logic [1:0] {
        SAVE_NONE  = 2'd0,
        SAVE_SRAM  = 2'd1,
        SAVE_BANK  = 2'd2,
        SAVE_FLASH = 2'd3
    } save_e;

    typedef struct packed {
        logic              bus;
        dev_e              dev;
        logic [ADDR_W-1:0] addr;
        logic              valid;
        logic              wr_ok;
    } xlat_t;

    localparam logic [ADDR_W-1:0] BASE_SAVE   = 32'h03FE_0000;
    localparam logic [ADDR_W-1:0] BASE_LOADER = 32'h03BC_0000;
    localparam logic [ADDR_W-1:0] BASE_BOOT   = 32'h04E0_0000;
    localparam logic [ADDR_W-1:0] BASE_SHADOW = 32'h04FE_0000;
    localparam logic [ADDR_W-1:0] BASE_EXT    = 32'h0400_0000;
    localparam logic [ADDR_W-1:0] BASE_BRAM   = 32'h0500_0000;
endpackage

// File: rtl/hwm_decode.sv
module hwm_decode
    import hwm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              boot_sel,
    input  logic              shadow_on,
    input  logic              ext_on,
    input  logic [1:0]        save_kind,
    input  logic [1:0]        disk_kind,
    input  logic              regs_on,
    input  logic              rom_wr_on,
    input  logic              flash_rd_reg,
    output xlat_t             res
);
    logic [HI_W-1:0] hi;
    logic            can_wr;

    assign hi = addr[ADDR_W-1:UNIT_W];

    always_comb begin
        res    = '0;
        can_wr = 1'b0;
        if (regs_on && hi == 16'h1FFF) begin
            res.valid = 1'b1; res.bus = 1'b1; res.dev = DEV_CTRL;
            res.addr  = {16'h0, addr[15:0]};
            can_wr    = 1'b1;
        end else if (regs_on && hi == 16'h1FFE) begin
            res.valid = 1'b1; res.dev = DEV_BRAM;
            res.addr  = BASE_BRAM + {16'h0, addr[15:0]};
            can_wr    = 1'b1;
        end else if (regs_on && hi[15:1] == 15'h0FFE) begin
            res.valid = 1'b1; res.dev = DEV_FLASH;
            res.addr  = BASE_SHADOW + {15'h0, addr[16:0]};
        end else if (shadow_on && hi[15:1] == 15'h09FF) begin
            res.valid = 1'b1; res.dev = DEV_FLASH;
            res.addr  = BASE_SHADOW + {15'h0, addr[16:0]};
        end else if (ext_on && hi >= 16'h1400 && hi < 16'h14E0) begin
            res.valid = 1'b1; res.dev = DEV_FLASH;
            res.addr  = BASE_EXT + {8'h0, addr[23:0]};
        end else if (boot_sel && hi >= 16'h1000 && hi < 16'h101E) begin
            res.valid = 1'b1; res.dev = DEV_FLASH;
            res.addr  = BASE_BOOT + {11'h0, addr[20:0]};
        end else if (!boot_sel && hi[15:10] == 6'b000100) begin
            res.valid = 1'b1; res.dev = DEV_SDRAM;
            res.addr  = {6'h0, addr[25:0]};
            can_wr    = rom_wr_on;
        end else if (hi[15:4] == 12'h080) begin
            case (save_e'(save_kind))
                SAVE_SRAM: if (hi[3:1] == 3'b000) begin
                    res.valid = 1'b1; res.dev = DEV_SDRAM;
                    res.addr  = BASE_SAVE + {15'h0, addr[16:0]};
                    can_wr    = 1'b1;
                end
                SAVE_BANK: if (hi[1:0] == 2'b00 && hi[3:2] != 2'b11) begin
                    res.valid = 1'b1; res.dev = DEV_SDRAM;
                    res.addr  = BASE_SAVE + {15'h0, hi[3:2], addr[14:0]};
                    can_wr    = 1'b1;
                end
                SAVE_FLASH: if (hi[3:1] == 3'b000) begin
                    res.valid = 1'b1;
                    can_wr    = 1'b1;
                    if (is_write || flash_rd_reg) begin
                        res.bus  = 1'b1; res.dev = DEV_FSAVE;
                        res.addr = {15'h0, addr[16:0]};
                    end else begin
                        res.dev  = DEV_SDRAM;
                        res.addr = BASE_SAVE + {15'h0, addr[16:0]};
                    end
                end
                default: ;
            endcase
        end else if (disk_kind[0] && hi == 16'h0500) begin
            res.valid = 1'b1; res.bus = 1'b1; res.dev = DEV_DISK;
            res.addr  = {16'h0, addr[15:0]};
            can_wr    = 1'b1;
        end else if (disk_kind[1] && hi[15:6] == 10'h018) begin
            res.valid = 1'b1; res.dev = DEV_SDRAM;
            res.addr  = BASE_LOADER + {10'h0, addr[21:0]};
        end
        res.wr_ok = res.valid && can_wr && is_write;
    end
endmodule

// File: rtl/hwm_hold.sv
module hwm_hold
    import hwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  strobe,
    input  xlat_t next,
    output xlat_t held
);
    typedef enum logic {S_EMPTY, S_HOLD} state_e;
    state_e state;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_EMPTY;
        end else begin
            unique case (state)
                S_EMPTY: if (strobe) state <= S_HOLD;
                S_HOLD:  state <= S_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (strobe) begin
            held <= next;
        end
    end

    a_r1_empty_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_EMPTY |-> !held.valid && held.addr == '0);

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(held));

    a_r12_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !held.valid |-> held.addr == '0 && held.dev == DEV_NONE && !held.bus && !held.wr_ok);

    a_r12_wr_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        held.wr_ok |-> held.valid);

    a_r11_flash_ro: assert property (@(posedge clk) disable iff (!rst_n)
        held.dev == DEV_FLASH |-> !held.wr_ok && !held.bus);

    a_r9_regbus_dev: assert property (@(posedge clk) disable iff (!rst_n)
        held.bus |-> held.dev == DEV_CTRL || held.dev == DEV_DISK || held.dev == DEV_FSAVE);
endmodule

// File: rtl/host_window_map.sv
module host_window_map
    import hwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [31:0]       start_addr,
    input  logic              is_write,
    input  logic              boot_sel,
    input  logic              shadow_on,
    input  logic              ext_on,
    input  logic [1:0]        save_kind,
    input  logic [1:0]        disk_kind,
    input  logic              regs_on,
    input  logic              rom_wr_on,
    input  logic              flash_rd_reg,
    output logic              bus_reg,
    output logic [2:0]        dev_sel,
    output logic [31:0]       int_addr,
    output logic              hit,
    output logic              wr_ok
);
    xlat_t dec_res;
    xlat_t cur;

    hwm_decode u_dec (
        .addr         (start_addr),
        .is_write     (is_write),
        .boot_sel     (boot_sel),
        .shadow_on    (shadow_on),
        .ext_on       (ext_on),
        .save_kind    (save_kind),
        .disk_kind    (disk_kind),
        .regs_on      (regs_on),
        .rom_wr_on    (rom_wr_on),
        .flash_rd_reg (flash_rd_reg),
        .res          (dec_res)
    );

    hwm_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .next   (dec_res),
        .held   (cur)
    );

    assign bus_reg  = cur.bus;
    assign dev_sel  = cur.dev;
    assign int_addr = cur.addr;
    assign hit      = cur.valid;
    assign wr_ok    = cur.wr_ok;
endmodule

// File: tb/sim_host_window_map.sv
module sim_host_window_map;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 85;
    localparam int NV = 33;

    // {tag[3:0], addr, wr, cfg{boot,shadow,ext,save[1:0],disk[1:0],regs,romwr,flrd}, bus, dev, eaddr, valid, wr_ok}
    localparam logic [VW-1:0] VECS [0:NV-1] = '{
        {4'd4,  32'h1000_1234, 1'b0, 10'b1_0_0_00_00_0_0_0, 1'b0, 3'd2, 32'h04E0_1234, 1'b1, 1'b0}, // R4
        {4'd4,  32'h101D_FFFC, 1'b1, 10'b1_0_0_00_00_0_0_0, 1'b0, 3'd2, 32'h04FD_FFFC, 1'b1, 1'b0}, // R4
        {4'd4,  32'h101E_0000, 1'b0, 10'b1_0_0_00_00_0_0_0, 1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}, // R4
        {4'd5,  32'h1234_5678, 1'b1, 10'b0_0_0_00_00_0_0_0, 1'b0, 3'd1, 32'h0234_5678, 1'b1, 1'b0}, // R5
        {4'd5,  32'h1234_5678, 1'b1, 10'b0_0_0_00_00_0_1_0, 1'b0, 3'd1, 32'h0234_5678, 1'b1, 1'b1}, // R5
        {4'd5,  32'h1000_0000, 1'b0, 10'b0_0_0_00_00_0_1_0, 1'b0, 3'd1, 32'h0000_0000, 1'b1, 1'b0}, // R5
        {4'd6,  32'h13FE_0010, 1'b1, 10'b0_1_0_00_00_0_1_0, 1'b0, 3'd2, 32'h04FE_0010, 1'b1, 1'b0}, // R6
        {4'd6,  32'h13FF_FFF0, 1'b0, 10'b0_0_0_00_00_0_0_0, 1'b0, 3'd1, 32'h03FF_FFF0, 1'b1, 1'b0}, // R6
        {4'd7,  32'h1401_0000, 1'b0, 10'b0_0_1_00_00_0_0_0, 1'b0, 3'd2, 32'h0401_0000, 1'b1, 1'b0}, // R7
        {4'd7,  32'h14DF_FFFC, 1'b1, 10'b0_0_1_00_00_0_0_0, 1'b0, 3'd2, 32'h04DF_FFFC, 1'b1, 1'b0}, // R7
        {4'd7,  32'h14E0_0000, 1'b0, 10'b0_0_1_00_00_0_0_0, 1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}, // R7
        {4'd7,  32'h1401_0000, 1'b0, 10'b0_0_0_00_00_0_0_0, 1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}, // R7
        {4'd8,  32'h0801_0004, 1'b1, 10'b0_0_0_01_00_0_0_0, 1'b0, 3'd1, 32'h03FF_0004, 1'b1, 1'b1}, // R8
        {4'd8,  32'h0804_1234, 1'b1, 10'b0_0_0_10_00_0_0_0, 1'b0, 3'd1, 32'h03FE_9234, 1'b1, 1'b1}, // R8
        {4'd8,  32'h0808_7FFC, 1'b0, 10'b0_0_0_10_00_0_0_0, 1'b0, 3'd1, 32'h03FF_7FFC, 1'b1, 1'b0}, // R8
        {4'd8,  32'h080C_0000, 1'b0, 10'b0_0_0_10_00_0_0_0, 1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}, // R8
        {4'd8,  32'h0801_0000, 1'b0, 10'b0_0_0_10_00_0_0_0, 1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}, // R8
        {4'd8,  32'h0800_0000, 1'b0, 10'b0_0_0_00_00_0_0_0, 1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}, // R8
        {4'd9,  32'h0800_0100, 1'b0, 10'b0_0_0_11_00_0_0_0, 1'b0, 3'd1, 32'h03FE_0100, 1'b1, 1'b0}, // R9
        {4'd9,  32'h0800_0100, 1'b0, 10'b0_0_0_11_00_0_0_1, 1'b1, 3'd6, 32'h0000_0100, 1'b1, 1'b0}, // R9
        {4'd9,  32'h0801_0200, 1'b1, 10'b0_0_0_11_00_0_0_0, 1'b1, 3'd6, 32'h0001_0200, 1'b1, 1'b1}, // R9
        {4'd10, 32'h0500_0040, 1'b1, 10'b0_0_0_00_01_0_0_0, 1'b1, 3'd5, 32'h0000_0040, 1'b1, 1'b1}, // R10
        {4'd10, 32'h0500_0040, 1'b1, 10'b0_0_0_00_10_0_0_0, 1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}, // R10
        {4'd10, 32'h0612_3456, 1'b1, 10'b0_0_0_00_10_0_0_0, 1'b0, 3'd1, 32'h03CE_3456, 1'b1, 1'b0}, // R10
        {4'd10, 32'h0612_3456, 1'b0, 10'b0_0_0_00_01_0_0_0, 1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}, // R10
        {4'd10, 32'h0500_0000, 1'b0, 10'b0_0_0_00_11_0_0_0, 1'b1, 3'd5, 32'h0000_0000, 1'b1, 1'b0}, // R10
        {4'd11, 32'h1FFF_0008, 1'b1, 10'b0_0_0_00_00_1_0_0, 1'b1, 3'd4, 32'h0000_0008, 1'b1, 1'b1}, // R11
        {4'd11, 32'h1FFF_0008, 1'b1, 10'b0_0_0_00_00_0_0_0, 1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}, // R11
        {4'd11, 32'h1FFE_2000, 1'b1, 10'b0_0_0_00_00_1_0_0, 1'b0, 3'd3, 32'h0500_2000, 1'b1, 1'b1}, // R11
        {4'd11, 32'h1FFD_0000, 1'b0, 10'b0_0_0_00_00_1_0_0, 1'b0, 3'd2, 32'h04FF_0000, 1'b1, 1'b0}, // R11
        {4'd12, 32'h0000_0000, 1'b1, 10'b0_1_1_01_11_1_1_0, 1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}, // R12
        {4'd12, 32'hFFFF_0000, 1'b0, 10'b0_1_1_01_11_1_1_0, 1'b0, 3'd0, 32'h0000_0000, 1'b0, 1'b0}, // R12
        {4'd3,  32'h1FFE_FFFC, 1'b0, 10'b0_0_0_00_00_1_0_0, 1'b0, 3'd3, 32'h0500_FFFC, 1'b1, 1'b0}  // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic [31:0] start_addr = '0;
    logic        is_write = 1'b0;
    logic [9:0]  cfg = '0;
    logic        bus_reg;
    logic [2:0]  dev_sel;
    logic [31:0] int_addr;
    logic        hit;
    logic        wr_ok;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_window_map u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe       (strobe),
        .start_addr   (start_addr),
        .is_write     (is_write),
        .boot_sel     (cfg[9]),
        .shadow_on    (cfg[8]),
        .ext_on       (cfg[7]),
        .save_kind    (cfg[6:5]),
        .disk_kind    (cfg[4:3]),
        .regs_on      (cfg[2]),
        .rom_wr_on    (cfg[1]),
        .flash_rd_reg (cfg[0]),
        .bus_reg      (bus_reg),
        .dev_sel      (dev_sel),
        .int_addr     (int_addr),
        .hit          (hit),
        .wr_ok        (wr_ok)
    );

    task automatic check(input int req, input string what, input logic [37:0] exp);
        logic [37:0] got;
        got = {bus_reg, dev_sel, int_addr, hit, wr_ok};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got bus=%0b dev=%0d addr=%h hit=%0b wr=%0b, expected bus=%0b dev=%0d addr=%h hit=%0b wr=%0b",
                     req, what, got[37], got[36:34], got[33:2], got[1], got[0],
                     exp[37], exp[36:34], exp[33:2], exp[1], exp[0]);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic w, input logic [9:0] c);
        @(negedge clk);
        start_addr = a; is_write = w; cfg = c; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog expired: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state before any strobe
        check(1, "reset state", 38'h0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VECS[i];
            apply(v[80:49], v[48], v[47:38]);
            check(int'(v[84:81]), $sformatf("vector %0d", i), v[37:0]);
        end

        // R2 / R3: latch block RAM unit, then cross into the register unit without a strobe
        apply(32'h1FFE_FFF0, 1'b1, 10'b0_0_0_00_00_1_0_0);
        check(11, "block RAM latch", {1'b0, 3'd3, 32'h0500_FFF0, 1'b1, 1'b1});
        @(negedge clk);
        start_addr = 32'h1FFF_0000; is_write = 1'b0; cfg = 10'b1_1_1_11_11_0_1_1;
        @(negedge clk);
        @(negedge clk);
        check(2, "hold across 64 KiB crossing", {1'b0, 3'd3, 32'h0500_FFF0, 1'b1, 1'b1});
        check(3, "first address keeps target", {1'b0, 3'd3, 32'h0500_FFF0, 1'b1, 1'b1});

        // R2: one-cycle latency, old value visible while strobe is high
        @(negedge clk);
        start_addr = 32'h0500_0010; is_write = 1'b1; cfg = 10'b0_0_0_00_01_0_0_0; strobe = 1'b1;
        #1;
        check(2, "before load edge", {1'b0, 3'd3, 32'h0500_FFF0, 1'b1, 1'b1});
        @(negedge clk);
        strobe = 1'b0;
        check(2, "after load edge", {1'b1, 3'd5, 32'h0000_0010, 1'b1, 1'b1});

        // R1: reset while holding clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "reset clears hold", 38'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule